// File: doc/BRIEF.md
# Round-Robin Request Arbiter

The arbiter chooses one of eight requesters per clock cycle and rotates priority so that every requester is served in turn. It has two parts. A small registered pointer holds the index of the requester that currently has top priority. A purely combinational priority selector takes the request vector and the pointer and returns a one-hot grant. The grant goes to the first active request found by scanning upward from the pointer, wrapping past the top index back to index 0. The grant appears in the same cycle as the requests that produce it.

A compile-time parameter chooses how the selector is built:
- **Bank**: one fixed-start encoder per pointer value, followed by a tree of 2-to-1 multiplexers.
- **Rotate**: rotate the requests, apply one fixed encoder, then rotate the result back.
- **Chain**: a scan chain started at the decoded pointer and unrolled across two copies of the request vector, so that no combinational loop exists.

All three structures give identical grants for every input.

The pointer is handled as a small state machine. Its state is the pointer value, 0 to N-1. Each clock edge takes one of three named transitions:
- **CLEAR**: a synchronous reset loads 0.
- **ADVANCE**: after a grant to index k, the pointer loads (k+1) mod N.
- **HOLD**: when no request is active, the pointer keeps its value.

Top module: `rr_arbiter`

## Requirements
- R1: The grant selects the first asserted request at or above the pointer index, including the pointer index itself, wrapping from index N-1 to index 0.
- R2: The grant is all zeros when no request is asserted. It is never more than one-hot, and it never marks a bit whose request is low.
- R3: After a cycle that grants index k, the pointer holds (k+1) mod N on the next clock edge (ADVANCE).
- R4: A cycle with no active request leaves the pointer unchanged (HOLD). This is observed through the grant to a later all-ones request.
- R5: A synchronous active-high reset sets the pointer to 0 (CLEAR). An all-ones request right after reset is granted at index 0.
- R6: The bank, rotate and chain structures produce bit-identical grants for every request pattern and every pointer value.
- R7: Under a continuous all-ones request, each requester is granted exactly once every N cycles.
- R8: The grant responds in the same cycle as the request. The only register in the block is the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the pointer |
| req_i | input | N (8) | One request bit per requester |
| gnt_o | output | N (8) | One-hot grant, or all zeros when there is no request |

## Verification
The assertions take for granted that `req_i` is stable and known around each rising edge. They also take for granted that reset is held for at least one edge before any pointer property is relied on. The bench changes requests only on falling edges and starts with reset asserted, so both conditions hold. Beyond those, the inputs are unconstrained: any request pattern is legal in any cycle. The stimulus therefore sweeps every pattern at every pointer value, and it reaches each pointer value only through legal grants.

// File: rtl/rr_pkg.sv
package rr_pkg;

    // Structure of the priority selector
    typedef enum logic [1:0] {
        PPE_BANK   = 2'd0,
        PPE_ROTATE = 2'd1,
        PPE_CHAIN  = 2'd2
    } ppe_kind_e;

    // Transition taken by the pointer register on a clock edge
    typedef enum logic [1:0] {
        PTR_HOLD    = 2'd0,
        PTR_ADVANCE = 2'd1,
        PTR_CLEAR   = 2'd2
    } ptr_step_e;

endpackage

// File: rtl/rr_ppe_bank.sv
module rr_ppe_bank #(
    parameter int N     = 8,
    parameter int PTR_W = $clog2(N)
) (
    input  logic [N-1:0]     req_i,
    input  logic [PTR_W-1:0] ptr_i,
    output logic [N-1:0]     gnt_o
);
    localparam int NODES = 2 * N - 1;

    // One fixed-start encoder per pointer value
    logic [N-1:0] cand [N];

    for (genvar p = 0; p < N; p++) begin : g_enc
        always_comb begin
            logic hit;
            hit = 1'b0;
            cand[p] = '0;
            for (int i = 0; i < N; i++) begin
                if (!hit && req_i[(p + i) % N]) begin
                    cand[p][(p + i) % N] = 1'b1;
                    hit = 1'b1;
                end
            end
        end
    end

    // Heap-ordered 2:1 mux tree, root selected by the pointer MSB
    logic [N-1:0] tree [NODES];

    for (genvar p = 0; p < N; p++) begin : g_leaf
        assign tree[N - 1 + p] = cand[p];
    end

    for (genvar d = 0; d < PTR_W; d++) begin : g_lvl
        for (genvar j = 0; j < (1 << d); j++) begin : g_node
            localparam int IDX = (1 << d) - 1 + j;
            assign tree[IDX] = ptr_i[PTR_W-1-d] ? tree[2*IDX+2] : tree[2*IDX+1];
        end
    end

    assign gnt_o = tree[0];

endmodule

// File: rtl/rr_ppe_rotate.sv
module rr_ppe_rotate #(
    parameter int N     = 8,
    parameter int PTR_W = $clog2(N)
) (
    input  logic [N-1:0]     req_i,
    input  logic [PTR_W-1:0] ptr_i,
    output logic [N-1:0]     gnt_o
);
    logic [2*N-1:0] down_w;
    logic [N-1:0]   rot_w;
    logic [N-1:0]   pick_w;
    logic [2*N-1:0] up_w;

    // Rotate so that the pointer index lands on bit 0
    assign down_w = {req_i, req_i} >> ptr_i;
    assign rot_w  = down_w[N-1:0];

    // Fixed encoder: lowest set bit wins
    assign pick_w = rot_w & (~rot_w + 1'b1);

    // Rotate back by the same amount in the other direction
    assign up_w  = {pick_w, pick_w} << ptr_i;
    assign gnt_o = up_w[2*N-1:N];

endmodule

// File: rtl/rr_ppe_chain.sv
module rr_ppe_chain #(
    parameter int N     = 8,
    parameter int PTR_W = $clog2(N)
) (
    input  logic [N-1:0]     req_i,
    input  logic [PTR_W-1:0] ptr_i,
    output logic [N-1:0]     gnt_o
);
    logic [N-1:0] start_w;

    // Decoded pointer marks where the scan begins
    always_comb begin
        start_w = '0;
        start_w[ptr_i] = 1'b1;
    end

    // Scan unrolled over two copies of the requests: no wrap-around loop
    always_comb begin
        logic armed;
        logic done;
        logic take;
        armed = 1'b0;
        done  = 1'b0;
        gnt_o = '0;
        for (int k = 0; k < 2 * N; k++) begin
            if (k < N && start_w[k]) begin
                armed = 1'b1;
            end
            take = armed && !done && req_i[k % N];
            if (take) begin
                gnt_o[k % N] = 1'b1;
            end
            done = done | take;
        end
    end

endmodule

// File: rtl/rr_ptr_reg.sv
module rr_ptr_reg
    import rr_pkg::*;
#(
    parameter int N     = 8,
    parameter int PTR_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     gnt_i,
    output logic [PTR_W-1:0] ptr_o
);
    ptr_step_e        step_w;
    logic [PTR_W-1:0] gidx_w;
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_d;

    // One-hot grant to index
    always_comb begin
        gidx_w = '0;
        for (int i = 0; i < N; i++) begin
            if (gnt_i[i]) begin
                gidx_w = gidx_w | PTR_W'(i);
            end
        end
    end

    always_comb begin
        if (rst) begin
            step_w = PTR_CLEAR;
        end else if (|gnt_i) begin
            step_w = PTR_ADVANCE;
        end else begin
            step_w = PTR_HOLD;
        end
    end

    always_comb begin
        unique case (step_w)
            PTR_CLEAR:   ptr_d = '0;
            PTR_ADVANCE: ptr_d = (gidx_w == PTR_W'(N - 1)) ? '0 : gidx_w + 1'b1;
            PTR_HOLD:    ptr_d = ptr_q;
            default:     ptr_d = ptr_q;
        endcase
    end

    always_ff @(posedge clk) begin
        ptr_q <= ptr_d;
    end

    assign ptr_o = ptr_q;

    AST_PTR_CLEAR: assert property (@(posedge clk) rst |=> ptr_q == '0); // R5
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (gnt_i == '0) |=> $stable(ptr_q)); // R4

endmodule

// File: rtl/rr_arbiter.sv
module rr_arbiter
    import rr_pkg::*;
#(
    parameter int        N        = 8,
    parameter ppe_kind_e PPE_KIND = PPE_BANK
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req_i,
    output logic [N-1:0] gnt_o
);
    localparam int PTR_W = $clog2(N);

    logic [PTR_W-1:0] ptr_w;
    logic [N-1:0]     gnt_w;
    logic [N-1:0]     ptr_dec_w;

    rr_ptr_reg #(.N(N), .PTR_W(PTR_W)) u_ptr (
        .clk   (clk),
        .rst   (rst),
        .gnt_i (gnt_w),
        .ptr_o (ptr_w)
    );

    if (PPE_KIND == PPE_ROTATE) begin : g_rotate
        rr_ppe_rotate #(.N(N), .PTR_W(PTR_W)) u_ppe (
            .req_i (req_i), .ptr_i (ptr_w), .gnt_o (gnt_w));
    end else if (PPE_KIND == PPE_CHAIN) begin : g_chain
        rr_ppe_chain #(.N(N), .PTR_W(PTR_W)) u_ppe (
            .req_i (req_i), .ptr_i (ptr_w), .gnt_o (gnt_w));
    end else begin : g_bank
        rr_ppe_bank #(.N(N), .PTR_W(PTR_W)) u_ppe (
            .req_i (req_i), .ptr_i (ptr_w), .gnt_o (gnt_w));
    end

    assign gnt_o = gnt_w;

    always_comb begin
        ptr_dec_w = '0;
        ptr_dec_w[ptr_w] = 1'b1;
    end

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt_w)); // R2
    AST_GNT_SUBSET: assert property (@(posedge clk) disable iff (rst)
        (gnt_w & ~req_i) == '0); // R2
    AST_GNT_NONZERO: assert property (@(posedge clk) disable iff (rst)
        (|req_i) |-> (|gnt_w)); // R1
    AST_START_WINS: assert property (@(posedge clk) disable iff (rst)
        (|(req_i & ptr_dec_w)) |-> (gnt_w == ptr_dec_w)); // R1
    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (|gnt_w) |=> (ptr_dec_w == {$past(gnt_w[N-2:0]), $past(gnt_w[N-1])})); // R3

endmodule

// File: tb/rr_arbiter_tb.sv
module rr_arbiter_tb;
    import rr_pkg::*;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] req = '0;
    logic [N-1:0] gnt_bank;
    logic [N-1:0] gnt_rot;
    logic [N-1:0] gnt_chain;

    int n_checks = 0;
    int n_fail   = 0;
    int ref_ptr  = 0;

    logic [N-1:0] exp_q  [$];
    string        tag_q  [$];
    bit           fair_q [$];

    always #5 clk = ~clk;

    rr_arbiter #(.N(N), .PPE_KIND(PPE_BANK))   u_dut       (.clk(clk), .rst(rst), .req_i(req), .gnt_o(gnt_bank));
    rr_arbiter #(.N(N), .PPE_KIND(PPE_ROTATE)) u_dut_rot   (.clk(clk), .rst(rst), .req_i(req), .gnt_o(gnt_rot));
    rr_arbiter #(.N(N), .PPE_KIND(PPE_CHAIN))  u_dut_chain (.clk(clk), .rst(rst), .req_i(req), .gnt_o(gnt_chain));

    function automatic logic [N-1:0] ref_grant(logic [N-1:0] r, int p);
        logic [N-1:0] g;
        g = '0;
        for (int i = 0; i < N; i++) begin
            if (r[(p + i) % N]) begin
                g[(p + i) % N] = 1'b1;
                break;
            end
        end
        return g;
    endfunction

    task automatic check(string tag, string who, logic [N-1:0] act, logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: gnt=%b expected=%b", tag, who, act, exp);
        end
    endtask

    // Driver: apply one request cycle and queue the expected grant
    task automatic drive(logic [N-1:0] r, string tag, bit fair);
        logic [N-1:0] e;
        @(negedge clk);
        req = r;
        e = ref_grant(r, ref_ptr);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        fair_q.push_back(fair);
        if (rst) begin
            ref_ptr = 0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (e[i]) ref_ptr = (i + 1) % N;
            end
        end
    endtask

    // Monitor: compare just before the next rising edge
    int mon_cyc = 0;
    int last_seen [N];
    initial begin
        for (int i = 0; i < N; i++) last_seen[i] = -1;
        forever begin
            @(negedge clk);
            #4;
            if (exp_q.size() > 0) begin
                logic [N-1:0] e;
                string t;
                bit f;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                f = fair_q.pop_front();
                check(t, "bank", gnt_bank, e);
                check(t, "rotate", gnt_rot, e);
                check(t, "chain", gnt_chain, e);
                if (f) begin
                    // R7: one grant per requester every N cycles
                    for (int i = 0; i < N; i++) begin
                        if (gnt_bank[i]) begin
                            if (last_seen[i] >= 0) begin
                                n_checks++;
                                if (mon_cyc - last_seen[i] != N) begin
                                    n_fail++;
                                    $display("FAIL R7 requester %0d: gap=%0d expected=%0d",
                                             i, mon_cyc - last_seen[i], N);
                                end
                            end
                            last_seen[i] = mon_cyc;
                        end
                    end
                end
                mon_cyc++;
            end
        end
    end

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        // Reset state: no request, no grant (R2, R5)
        drive('0, "R5", 1'b0);
        drive('0, "R5", 1'b0);
        @(negedge clk);
        rst = 1'b0;
        ref_ptr = 0;
        drive('1, "R5", 1'b0);            // start at index 0
        drive('0, "R2", 1'b0);

        // R4: pointer at 5, then idle cycles leave it there
        drive(8'b0001_0000, "R3", 1'b0);
        drive('0, "R4", 1'b0);
        drive('0, "R4", 1'b0);
        drive('0, "R4", 1'b0);
        drive('1, "R4", 1'b0);            // expect bit 5

        // R3 wrap: grant at top index moves pointer to 0
        drive(8'b1000_0000, "R3", 1'b0);
        drive(8'b1000_0001, "R3", 1'b0);  // expect bit 0

        // Full sweep: every pattern at every pointer value (R1, R6, R8)
        for (int p = 0; p < N; p++) begin
            for (int pat = 0; pat < 256; pat++) begin
                drive(N'(1 << ((p + N - 1) % N)), "R3", 1'b0);
                drive(N'(pat), "R1/R6/R8", 1'b0);
            end
        end

        // R7: continuous all-ones request
        for (int c = 0; c < 4 * N; c++) begin
            drive('1, "R7", 1'b1);
        end

        // R5: mid-run synchronous reset
        drive(8'b0000_1000, "R3", 1'b0);  // pointer to 4
        @(negedge clk);
        rst = 1'b1;
        drive('0, "R5", 1'b0);
        @(negedge clk);
        rst = 1'b0;
        drive('1, "R5", 1'b0);            // expect bit 0

        drive('0, "R2", 1'b0);
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule